// File: doc/BRIEF.md
# Four-Beat Burst Split-Bus SRAM Core

This block is a synchronous memory with one bus for write data and a separate bus for read data. A command (read, write or idle) and a wide-word address are taken once per command cycle. Every access moves exactly four data beats. The data buses run at double rate, so a burst fills two command cycles. The block is modelled on a single beat clock that runs at twice the command rate. An internal phase bit marks which rising edges are command edges, and the block shows that bit on `cmd_edge`.

Incoming write beats are gathered in an accumulation register and written to the array as one word four beats wide, in a single access. A read fetches one wide word and sends it out lowest beat first, three command cycles after the command was taken. A valid flag rises one beat ahead of the data. A read that hits a write which has not yet been committed gets the new data through a bypass from the accumulation register. Command conflicts are resolved by fixed rules and reported on a one-beat error pulse.

Top module: `qb4_sram`

## Requirements
- R1: `rd_n`, `wr_n` and `addr` are sampled only on a command edge, which is a rising edge of `clk` while `cmd_edge` is 1. `cmd_edge` alternates every beat and is 1 on the first edge after reset. Commands driven on other edges have no effect.
- R2: Both commands are active-low. `rd_n`=0 requests a read and `wr_n`=0 requests a write.
- R3: An accepted write at edge T takes its four beats from `wdata` on edges T, T+1, T+2 and T+3. Beat i fills bits [i*DW +: DW] of the wide word. The word is committed to `addr` at edge T+3.
- R4: For a read accepted at edge T, the beats of the wide word appear on `rdata` after edges T+6 through T+9 (three command cycles), beat 0 first. `rdata` is 0 whenever no read beat is being presented.
- R5: `rvalid` goes to 1 after edge T+5, one beat before the first data beat. It stays at 1 through the last beat and falls after T+10 unless a following burst continues it.
- R6: If both commands are low on the same command edge, the read is taken, the write is dropped and `cmd_err` pulses for one beat.
- R7: A read request on the command edge right after an accepted read is ignored and pulses `cmd_err`.
- R8: A write request on the command edge right after an accepted write is ignored and pulses `cmd_err`. The first write completes unchanged.
- R9: A read taken on the command edge right after a write to the same address returns the new write data.
- R10: Active-high `rst` clears the phase, the pipelines, `rvalid`, `rdata` and `cmd_err`, and cancels any burst in flight.
- R11: Reads spaced two command cycles apart give gapless data with `rvalid` held high across both bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, twice the command rate |
| rst | input | 1 | Active-high reset |
| rd_n | input | 1 | Read request, active-low |
| wr_n | input | 1 | Write request, active-low |
| addr | input | BEAT_AW-2 | Wide-word address |
| wdata | input | DW | Write data beat |
| cmd_edge | output | 1 | Next rising edge samples commands |
| rvalid | output | 1 | Read data valid, leads data by one beat |
| rdata | output | DW | Read data beat |
| cmd_err | output | 1 | One-beat pulse on a dropped or ignored command |

## Verification
The bench builds the block with its default values: 18-bit beats, an 8-bit beat address (64 wide words) and a three-cycle latency. At this size the whole latency window of ten beats, the overlap of a write's last beat with a following read's fetch, and two reads issued back to back fit in short directed sequences. Each beat position is given a distinct value, so a lane swap or an off-by-one in the latency count shows up at the ports.

// File: rtl/qb4_sram.sv
`timescale 1ns/1ps
module qb4_sram #(
  parameter int DW      = 18,
  parameter int BEAT_AW = 8,
  parameter int RD_LAT  = 3,
  localparam int AW     = BEAT_AW - 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          cmd_edge,
  output logic          rvalid,
  output logic [DW-1:0] rdata,
  output logic          cmd_err
);
  localparam int WW    = 4 * DW;
  localparam int DEPTH = 1 << AW;
  localparam int LD    = 2 * RD_LAT - 2;
  localparam int FIRST = 2 * RD_LAT - 1;
  localparam int LAST  = 2 * RD_LAT + 2;
  localparam int PL    = LAST + 1;

  logic          ph;
  logic [PL-1:0] rpipe;
  logic [AW-1:0] rd_addr, waddr;
  logic          wbusy;
  logic [1:0]    wcnt;
  logic [3*DW-1:0] wacc;
  logic [WW-1:0] mem [DEPTH];
  logic [WW-1:0] rhold, rsr;

  assign cmd_edge = ~ph;

  wire rd_req = cmd_edge & ~rd_n;
  wire wr_req = cmd_edge & ~wr_n;
  wire rd_blk = rpipe[1];
  wire wr_blk = wbusy & (wcnt == 2'd2);
  wire rd_acc = rd_req & ~rd_blk;
  wire wr_acc = wr_req & rd_n & ~wr_blk;
  wire err_d  = (rd_req & rd_blk) | (wr_req & (~rd_n | wr_blk));

  wire          commit = wbusy & (wcnt == 2'd3);
  wire [WW-1:0] wword  = {wdata, wacc};
  wire [WW-1:0] fetch  = (commit && waddr == rd_addr) ? wword : mem[rd_addr];
  wire          shout  = |rpipe[LAST:FIRST];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ph      <= 1'b0;
      rpipe   <= '0;
      cmd_err <= 1'b0;
      rd_addr <= '0;
    end else begin
      ph      <= ~ph;
      rpipe   <= {rpipe[PL-2:0], rd_acc};
      cmd_err <= err_d;
      if (rd_acc) rd_addr <= addr;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wbusy <= 1'b0;
      wcnt  <= '0;
      wacc  <= '0;
      waddr <= '0;
    end else if (wr_acc) begin
      wbusy          <= 1'b1;
      wcnt           <= 2'd1;
      wacc[DW-1:0]   <= wdata;
      waddr          <= addr;
    end else if (wbusy) begin
      wcnt <= wcnt + 2'd1;
      case (wcnt)
        2'd1: wacc[DW +: DW]   <= wdata;
        2'd2: wacc[2*DW +: DW] <= wdata;
        default: wbusy <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[waddr] <= wword;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rhold  <= '0;
      rsr    <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      if (rpipe[0]) rhold <= fetch;
      if (rpipe[LD]) rsr <= rhold;
      else if (shout) rsr <= rsr >> DW;
      rdata  <= shout ? rsr[DW-1:0] : '0;
      rvalid <= |rpipe[LAST:LD];
    end
  end

  p_cmd_alt_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_edge |=> !cmd_edge);
  p_err_on_cmd_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> !cmd_edge);
  p_commit_once_r3: assert property (@(posedge clk) disable iff (rst)
    commit |=> !wbusy);
  p_data_in_window_r4: assert property (@(posedge clk) disable iff (rst)
    (rdata != '0) |-> rvalid);
  p_valid_lead_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(rvalid) |=> rvalid);
  p_both_err_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_edge && !rd_n && !wr_n) |=> cmd_err && !wbusy);
  p_rd_b2b_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_edge && !rd_n && rpipe[1]) |=> cmd_err && !rpipe[0]);
  p_wr_b2b_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_edge && !wr_n && wbusy && wcnt == 2'd2) |=> cmd_err && wcnt == 2'd3);
endmodule

// File: tb/qb4_sram_tb_top.sv
`timescale 1ns/1ps
module qb4_sram_tb_top;
  localparam int DW = 18, BAW = 8, LAT = 3, AW = BAW - 2, WW = 4 * DW;
  localparam int L2 = 2 * LAT;

  logic clk = 0, rst = 1, rd_n = 1, wr_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic cmd_edge, rvalid, cmd_err;
  logic [DW-1:0] rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  qb4_sram #(.DW(DW), .BEAT_AW(BAW), .RD_LAT(LAT)) dut_i (
    .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
    .cmd_edge(cmd_edge), .rvalid(rvalid), .rdata(rdata), .cmd_err(cmd_err));

  always #4 clk = ~clk;

  localparam logic [WW-1:0] W1 = {18'h3A001, 18'h2B002, 18'h1C003, 18'h0D004};
  localparam logic [WW-1:0] W2 = {18'h01111, 18'h12222, 18'h23333, 18'h34444};
  localparam logic [WW-1:0] W3 = {18'h05A5A, 18'h1A5A5, 18'h2F0F0, 18'h30F0F};
  localparam logic [WW-1:0] W4 = {18'h3FFFE, 18'h00001, 18'h2AAAA, 18'h15555};
  localparam logic [WW-1:0] WX = {18'h0BEEF, 18'h0CAFE, 18'h0FACE, 18'h0DEAD};

  function automatic logic [DW-1:0] beat(input logic [WW-1:0] w, input int i);
    return w[i*DW +: DW];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step; @(negedge clk); endtask
  task automatic idle; rd_n = 1; wr_n = 1; wdata = '0; endtask
  task automatic to_cmd; while (!cmd_edge) step(); endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [WW-1:0] w);
    to_cmd();
    wr_n = 0; addr = a; wdata = beat(w, 0); step();
    wr_n = 1; wdata = beat(w, 1); step();
    wdata = beat(w, 2); step();
    wdata = beat(w, 3); step();
    idle();
  endtask

  task automatic read_collect(input logic [WW-1:0] exp, input int k0, input string req);
    for (int k = k0 + 1; k <= L2 + 5; k++) begin
      step(); idle();
      if (k == L2) chk(rvalid && rdata == '0, {req, " lead"}, {rvalid, rdata}, {1'b1, {DW{1'b0}}});
      else if (k > L2 && k <= L2 + 4)
        chk(rvalid && rdata == beat(exp, k - L2 - 1), {req, " beat"}, {rvalid, rdata}, {1'b1, beat(exp, k - L2 - 1)});
      else if (k == L2 + 5) chk(!rvalid, {req, " end"}, rvalid, 0);
      else if (k < L2) chk(!rvalid, {req, " early"}, rvalid, 0);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [WW-1:0] exp, input string req);
    to_cmd();
    rd_n = 0; addr = a;
    read_collect(exp, 0, req);
  endtask

  task automatic t_reset;
    chk(rvalid == 0 && rdata == 0 && cmd_err == 0, "R10 reset outputs", {rvalid, rdata, cmd_err}, 0);
    chk(cmd_edge == 1, "R1 first edge is command", cmd_edge, 1);
  endtask

  task automatic t_write_read;
    do_write(6'd1, W1);
    do_write(6'd2, W2);
    do_write(6'd63, W3);
    do_read(6'd1, W1, "R3 R4 R5 R2 addr1");
    do_read(6'd2, W2, "R3 R4 addr2");
    do_read(6'd63, W3, "R3 top addr");
  endtask

  task automatic t_offedge;
    to_cmd(); step();
    rd_n = 0; wr_n = 0; addr = 6'd1; wdata = 18'h3FFFF;
    step(); idle();
    for (int k = 0; k < 12; k++) begin
      chk(!rvalid && !cmd_err, "R1 off-edge ignored", {rvalid, cmd_err}, 0);
      step();
    end
    do_read(6'd1, W1, "R1 off-edge write ignored");
  endtask

  task automatic t_both;
    to_cmd();
    rd_n = 0; wr_n = 0; addr = 6'd1; wdata = beat(WX, 0);
    step(); idle();
    chk(cmd_err, "R6 both err", cmd_err, 1);
    read_collect(W1, 1, "R6 read wins");
    do_read(6'd1, W1, "R6 write dropped");
  endtask

  task automatic t_rd_b2b;
    to_cmd();
    rd_n = 0; addr = 6'd1; step(); idle(); step();
    rd_n = 0; addr = 6'd2; step(); idle();
    chk(cmd_err, "R7 b2b read err", cmd_err, 1);
    read_collect(W1, 3, "R7 only first burst");
  endtask

  task automatic t_rd_pair;
    to_cmd();
    rd_n = 0; addr = 6'd1;
    for (int k = 1; k <= L2 + 9; k++) begin
      step(); idle();
      if (k == 4) begin rd_n = 0; addr = 6'd2; end
      if (k == 5) chk(!cmd_err, "R11 spaced read accepted", cmd_err, 0);
      if (k >= L2 && k <= L2 + 8) chk(rvalid, "R11 valid continuous", rvalid, 1);
      if (k > L2 && k <= L2 + 4) chk(rdata == beat(W1, k - L2 - 1), "R11 first burst", rdata, beat(W1, k - L2 - 1));
      if (k > L2 + 4 && k <= L2 + 8) chk(rdata == beat(W2, k - L2 - 5), "R11 second burst", rdata, beat(W2, k - L2 - 5));
      if (k == L2 + 9) chk(!rvalid, "R11 valid falls", rvalid, 0);
    end
  endtask

  task automatic t_wr_b2b;
    to_cmd();
    wr_n = 0; addr = 6'd5; wdata = beat(W3, 0); step();
    wr_n = 1; wdata = beat(W3, 1); step();
    wr_n = 0; addr = 6'd5; wdata = beat(W3, 2); step();
    wr_n = 1; wdata = beat(W3, 3);
    chk(cmd_err, "R8 b2b write err", cmd_err, 1);
    step(); idle();
    step(); step(); step(); step();
    do_read(6'd5, W3, "R8 first write intact");
  endtask

  task automatic t_bypass;
    to_cmd();
    wr_n = 0; addr = 6'd7; wdata = beat(W4, 0); step();
    wr_n = 1; wdata = beat(W4, 1); step();
    rd_n = 0; addr = 6'd7; wdata = beat(W4, 2); step();
    rd_n = 1; wdata = beat(W4, 3);
    chk(!cmd_err, "R9 no conflict", cmd_err, 0);
    read_collect(W4, 1, "R9 bypass");
    do_read(6'd7, W4, "R9 committed");
  endtask

  task automatic t_reset_mid;
    to_cmd();
    rd_n = 0; addr = 6'd1; step(); idle();
    step(); step(); step(); step();
    rst = 1; step(); step();
    chk(!rvalid && rdata == 0 && !cmd_err, "R10 mid reset", {rvalid, rdata, cmd_err}, 0);
    rst = 0;
    chk(cmd_edge, "R10 phase reset", cmd_edge, 1);
    for (int k = 0; k < 10; k++) begin
      step();
      chk(!rvalid, "R10 burst cancelled", rvalid, 0);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) step();
    rst = 0;
    t_reset();
    t_write_read();
    t_offedge();
    t_both();
    t_rd_b2b();
    t_rd_pair();
    t_wr_b2b();
    t_bypass();
    t_reset_mid();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule